// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave

This block models a read-only 256-byte serial EEPROM. A register-driven master moves the clock and data lines by software. Each time the master changes the line levels it pulses `strobe` for one clock and presents the new `scl_in` and `sda_in` values. The slave keeps the last clock and data levels it saw. From those it finds the start condition, the stop condition and the clock rising edges. It then steps one tick counter through a command byte and an address byte.

After the command byte the slave acknowledges. While the address byte is clocked in, a read command (command LSB set) makes the slave shift out the byte it latched on the previous transfer, most significant bit first. At the end of the address byte the slave latches the byte stored at that address and acknowledges again. The counter then returns to zero and the slave waits for a new start. The stored data-line level is the slave's output, and the master reads it back. The contents come from an elaboration-time formula chosen by parameters.

Top module: `bbeep_slave`

## Requirements
- R1: After reset `sda_out` is 1, the slave is idle, and the latched data byte is 0x00, so the first read transfer after reset shifts out eight zeros.
- R2: A strobe with SCL high at both the old and new level and SDA going 1 to 0 is a start. It sets the tick counter to 1 and clears the command, even in the middle of a transfer. SDA going 0 to 1 with SCL held high is a stop, and a stop changes no transfer state.
- R3: While the tick counter is 0 and no acknowledge is pending, clock edges are ignored and `sda_out` follows the master's SDA.
- R4: A rising SCL edge on which SDA also changes is not taken as a bit and does not advance the counter.
- R5: After the eighth command bit (MSB first) an acknowledge is pending. On the next rising SCL edge `sda_out` is 0 whatever the master drives.
- R6: For a read command (command bit 0 = 1), on each of the eight address-bit rising edges `sda_out` is the MSB of the latched data byte before it shifts left. The bits therefore appear MSB first.
- R7: After the eighth address bit (MSB first) the slave latches the addressed byte and acknowledges on the next rising edge. It is then idle until a new start.
- R8: The byte stored at address a is (a*ROM_MUL + ROM_ADD) mod 2^DATA_W, with defaults 29 and 90 (ROM_MODE 0).
- R9: For a write command (command bit 0 = 0), `sda_out` follows the master's SDA during the address bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | One-cycle pulse: new line levels are valid |
| scl_in | input | 1 | Clock level set by the master |
| sda_in | input | 1 | Data level set by the master |
| sda_out | output | 1 | Data level presented by the slave |

## Verification
The hardest case to reach from the ports is a data byte that appears only one transfer later. The byte latched at the end of one address phase is shifted out during the address phase of the next read. The stimulus therefore chains read and write transfers from a vector table, and the bench carries a model of the latched byte from one transfer into the next. The mid-transfer stop, a restart during the command byte and a glitched clock edge are each placed between ordinary bits. The effect of each is seen as the position of the acknowledge low.

// File: rtl/bbeep_pkg.sv
package bbeep_pkg;

   // contents variants selectable at elaboration
   typedef enum int {
      ROM_AFFINE = 0,
      ROM_FILL   = 1
   } rom_mode_e;

   // classified line activity for one strobe
   typedef struct packed {
      logic start;   // SDA fell with SCL high
      logic stop;    // SDA rose with SCL high
      logic rise;    // SCL rose
      logic steady;  // SDA equals the stored level
   } line_ev_t;

   function automatic int unsigned rom_word(input int unsigned idx,
                                            input int unsigned mul,
                                            input int unsigned add,
                                            input int mode);
      if (mode == ROM_FILL) return add;
      return idx * mul + add;
   endfunction

endpackage

// File: rtl/bbeep_line_mon.sv
module bbeep_line_mon
   import bbeep_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     strobe,
   input  logic     scl_in,
   input  logic     sda_in,
   input  logic     drv_en,
   input  logic     drv_val,
   output line_ev_t ev,
   output logic     sda_level
);

   logic scl_q;
   logic sda_q;
   logic both_high;
   logic sda_moved;

   assign both_high = scl_q & scl_in;
   assign sda_moved = sda_q ^ sda_in;

   always_comb begin
      ev.start  = strobe & both_high & sda_moved & ~sda_in;
      ev.stop   = strobe & both_high & sda_moved & sda_in;
      ev.rise   = strobe & ~scl_q & scl_in;
      ev.steady = ~sda_moved;
   end

   // stored levels; the data level may be overridden by the slave
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else if (strobe) begin
         scl_q <= scl_in;
         sda_q <= drv_en ? drv_val : sda_in;
      end
   end

   assign sda_level = sda_q;

   // R2
   evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev.start, ev.stop, ev.rise}));

   // R3
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(sda_q) && $stable(scl_q));

endmodule

// File: rtl/bbeep_rom.sv
module bbeep_rom
   import bbeep_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter int          ROM_MODE = ROM_AFFINE,
   parameter int unsigned ROM_MUL  = 29,
   parameter int unsigned ROM_ADD  = 90
) (
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   generate
      if (ROM_MODE == ROM_FILL) begin : g_fill
         for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign cells[i] = DATA_W'(rom_word(i, ROM_MUL, ROM_ADD, ROM_FILL));
         end
      end else begin : g_affine
         for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign cells[i] = DATA_W'(rom_word(i, ROM_MUL, ROM_ADD, ROM_AFFINE));
         end
      end
   endgenerate

   assign rd_data = cells[rd_addr];

endmodule

// File: rtl/bbeep_xfer_core.sv
module bbeep_xfer_core
   import bbeep_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int CMD_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  line_ev_t          ev,
   input  logic              sda_in,
   input  logic [DATA_W-1:0] rom_data,
   output logic [ADDR_W-1:0] rom_addr,
   output logic              drv_en,
   output logic              drv_val,
   output logic              ack_pend
);

   localparam int TICK_LAST = CMD_W + ADDR_W + 1;
   localparam int TICK_W    = $clog2(TICK_LAST + 1);
   localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);
   localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(CMD_W + 1);
   localparam logic [TICK_W-1:0] T_LAST = TICK_W'(TICK_LAST);

   logic [TICK_W-1:0] tick_q, tick_d;
   logic [CMD_W-1:0]  cmd_q, cmd_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic [DATA_W-1:0] data_q, data_d;
   logic              ack_q, ack_d;
   logic              idle;
   logic              take_bit;

   assign idle     = (tick_q == '0) && !ack_q;
   assign take_bit = ev.rise & ev.steady;
   assign rom_addr = {addr_q[ADDR_W-2:0], sda_in};

   always_comb begin
      tick_d  = tick_q;
      cmd_d   = cmd_q;
      addr_d  = addr_q;
      data_d  = data_q;
      ack_d   = ack_q;
      drv_en  = 1'b0;
      drv_val = 1'b1;
      if (ev.start) begin
         tick_d = T_ONE;
         cmd_d  = '0;
      end else if (ev.stop || idle) begin
         // nothing changes
      end else if (ev.rise) begin
         if (ack_q) begin
            drv_en  = 1'b1;
            drv_val = 1'b0;
            ack_d   = 1'b0;
         end else if (take_bit) begin
            if (tick_q < T_CMD) begin
               cmd_d  = {cmd_q[CMD_W-2:0], sda_in};
               tick_d = tick_q + T_ONE;
               if (tick_q == T_CMD - T_ONE) ack_d = 1'b1;
            end else begin
               if (cmd_q[0]) begin
                  drv_en  = 1'b1;
                  drv_val = data_q[DATA_W-1];
               end
               addr_d = rom_addr;
               data_d = data_q << 1;
               if (tick_q == T_LAST - T_ONE) begin
                  data_d = rom_data;
                  ack_d  = 1'b1;
                  tick_d = '0;
               end else begin
                  tick_d = tick_q + T_ONE;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tick_q <= '0;
         cmd_q  <= '0;
         addr_q <= '0;
         data_q <= '0;
         ack_q  <= 1'b0;
      end else begin
         tick_q <= tick_d;
         cmd_q  <= cmd_d;
         addr_q <= addr_d;
         data_q <= data_d;
         ack_q  <= ack_d;
      end
   end

   assign ack_pend = ack_q;

   // R2
   start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev.start |=> (tick_q == T_ONE) && (cmd_q == '0));

   // R3
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !ev.start) |=> $stable(tick_q) && $stable(cmd_q)
                              && $stable(data_q) && !ack_q);

   // R4
   glitch_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev.rise && !ev.steady && !ack_q) |=> $stable(tick_q) && $stable(addr_q));

   // R5
   cmd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_bit && !ack_q && tick_q == T_CMD - T_ONE) |=> ack_q && tick_q == T_CMD);

   // R7
   addr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_bit && !ack_q && tick_q == T_LAST - T_ONE) |=> ack_q && tick_q == '0);

   // R7
   tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q < T_LAST);

endmodule

// File: rtl/bbeep_slave.sv
module bbeep_slave
   import bbeep_pkg::*;
#(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter int          CMD_W    = 8,
   parameter int          ROM_MODE = ROM_AFFINE,
   parameter int unsigned ROM_MUL  = 29,
   parameter int unsigned ROM_ADD  = 90
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_out
);

   generate
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("bbeep_slave: ADDR_W must be 2..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("bbeep_slave: DATA_W must be at least 1");
      end
      if (CMD_W < 2) begin : g_bad_cmd
         $error("bbeep_slave: CMD_W must be at least 2");
      end
      if (ROM_MODE != ROM_AFFINE && ROM_MODE != ROM_FILL) begin : g_bad_mode
         $error("bbeep_slave: unknown ROM_MODE");
      end
   endgenerate

   line_ev_t          ev;
   logic              drv_en;
   logic              drv_val;
   logic              ack_pend;
   logic [ADDR_W-1:0] rom_addr;
   logic [DATA_W-1:0] rom_data;

   bbeep_line_mon u_mon (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe    (strobe),
      .scl_in    (scl_in),
      .sda_in    (sda_in),
      .drv_en    (drv_en),
      .drv_val   (drv_val),
      .ev        (ev),
      .sda_level (sda_out)
   );

   bbeep_rom #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ROM_MODE (ROM_MODE),
      .ROM_MUL  (ROM_MUL),
      .ROM_ADD  (ROM_ADD)
   ) u_rom (
      .rd_addr (rom_addr),
      .rd_data (rom_data)
   );

   bbeep_xfer_core #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CMD_W  (CMD_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       (ev),
      .sda_in   (sda_in),
      .rom_data (rom_data),
      .rom_addr (rom_addr),
      .drv_en   (drv_en),
      .drv_val  (drv_val),
      .ack_pend (ack_pend)
   );

   // R5
   ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_pend && ev.rise) |=> !sda_out);

   // R9
   mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !drv_en) |=> sda_out == $past(sda_in));

endmodule

// File: tb/bbeep_slave_tb.sv
module bbeep_slave_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // {command, address}
   localparam logic [15:0] VEC [NVEC] = '{
      16'hA1_05, 16'hA1_40, 16'hA0_7F, 16'hA1_FF, 16'hA1_00, 16'hA0_12
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe = 1'b0;
   logic scl_in = 1'b1;
   logic sda_in = 1'b1;
   logic sda_out;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] dm = 8'h00;   // model of the latched byte

   always #(CLK_PERIOD/2) clk = ~clk;

   bbeep_slave u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .strobe  (strobe),
      .scl_in  (scl_in),
      .sda_in  (sda_in),
      .sda_out (sda_out)
   );

   function automatic logic [7:0] rom_exp(input logic [7:0] a);
      return 8'((int'(a) * 29 + 90) & 255);
   endfunction

   task automatic chk(input logic got, input logic exp, input string req, input string what);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
      end
   endtask

   task automatic ev(input logic c, input logic d);
      @(negedge clk);
      scl_in = c;
      sda_in = d;
      strobe = 1'b1;
      @(negedge clk);
      strobe = 1'b0;
   endtask

   task automatic do_start();
      ev(1'b0, 1'b1);
      ev(1'b1, 1'b1);
      ev(1'b1, 1'b0);
   endtask

   task automatic bit_out(input logic b);
      ev(1'b0, b);
      ev(1'b1, b);
   endtask

   // address phase plus final acknowledge and one idle edge
   task automatic addr_phase(input logic [7:0] cmd, input logic [7:0] a);
      for (int i = 7; i >= 0; i--) begin
         bit_out(a[i]);
         if (cmd[0]) chk(sda_out, dm[i], "R6/R8", "read data bit");
         else        chk(sda_out, a[i], "R9", "write mirror bit");
      end
      bit_out(1'b1);
      chk(sda_out, 1'b0, "R7", "address acknowledge");
      dm = rom_exp(a);
      bit_out(1'b1);
      chk(sda_out, 1'b1, "R7", "idle after address");
   endtask

   task automatic xfer(input logic [7:0] cmd, input logic [7:0] a);
      do_start();
      for (int i = 7; i >= 0; i--) bit_out(cmd[i]);
      bit_out(1'b1);
      chk(sda_out, 1'b0, "R5", "command acknowledge");
      addr_phase(cmd, a);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset level
      chk(sda_out, 1'b1, "R1", "sda_out after reset");

      // vector table: chained read/write transfers
      for (int k = 0; k < NVEC; k++) xfer(VEC[k][15:8], VEC[k][7:0]);

      // R3: nine clocks with no start must not produce an acknowledge
      for (int i = 0; i < 9; i++) bit_out(1'b1);
      chk(sda_out, 1'b1, "R3", "no ack while idle");
      bit_out(1'b0);
      chk(sda_out, 1'b0, "R3", "idle mirrors low");
      bit_out(1'b1);
      chk(sda_out, 1'b1, "R3", "idle mirrors high");

      // R4: glitched rising edge inserted after command bit 5
      begin
         logic [7:0] c = 8'hA3;
         do_start();
         for (int i = 7; i >= 0; i--) begin
            bit_out(c[i]);
            if (i == 5) begin
               ev(1'b0, 1'b0);
               ev(1'b1, 1'b1);
            end
         end
         chk(sda_out, 1'b1, "R4", "no early ack after glitch");
         bit_out(1'b1);
         chk(sda_out, 1'b0, "R4", "ack after eight real bits");
         addr_phase(c, 8'h33);
      end

      // R2: stop in the middle of the command is ignored
      begin
         logic [7:0] c = 8'hC1;
         do_start();
         for (int i = 7; i >= 5; i--) bit_out(c[i]);
         ev(1'b1, 1'b1);               // stop: SCL high, SDA 0 -> 1
         for (int i = 4; i >= 0; i--) bit_out(c[i]);
         chk(sda_out, 1'b1, "R2", "no ack before eighth bit");
         bit_out(1'b1);
         chk(sda_out, 1'b0, "R2", "ack after stop ignored");
         addr_phase(c, 8'h80);
      end

      // R2: restart during the command restarts the count
      begin
         logic [7:0] c = 8'hA1;
         do_start();
         for (int i = 0; i < 5; i++) bit_out(1'b0);
         do_start();
         for (int i = 7; i >= 0; i--) bit_out(c[i]);
         chk(sda_out, 1'b1, "R2", "no ack before restart count ends");
         bit_out(1'b1);
         chk(sda_out, 1'b0, "R2", "ack after restart");
         addr_phase(c, 8'hC4);
      end

      // R1: reset in mid-transfer, then a read shifts out zeros
      do_start();
      for (int i = 0; i < 4; i++) bit_out(1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      scl_in = 1'b1;
      sda_in = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sda_out, 1'b1, "R1", "sda_out after second reset");
      dm = 8'h00;
      xfer(8'hA1, 8'h21);
      xfer(8'hA1, 8'h00);   // R8: shows contents of 0x21

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule